// File: doc/BRIEF.md
# Faulty-location error bank

This block keeps a small associative list of cache locations, each an index plus a way, that recovery logic has found to hold corrupted data. Once a location is recorded, every tag lookup that addresses it sees its valid bit forced low, and the allocation query for that index reports the way as unavailable. Without this, a hard fault would be refilled and retried over and over.

Locations arrive on two push ports. The local port is fed by the cache's own ECC recovery path. The forwarded port carries errors that a coherency unit reports back for lines it can no longer hold. An entry stays in force until software clears it by entry number. Status outputs give the number of recorded locations and show whether the bank is empty, holds at least one error, or is full. A full bank means further faults cannot be masked and the system risks livelock.

Top module: `bad_loc_bank`

## Requirements
- R1: A local push of (index, way) is recorded at the next rising clock edge. From then on, a lookup of that pair returns `lk_valid_out` = 0 even when `lk_valid_in` = 1.
- R2: `lk_valid_out` equals `lk_valid_in` AND NOT (the looked-up index/way is recorded). A location that differs in either index or way passes through unchanged.
- R3: `alloc_ok` bit w is 0 exactly when (`alloc_idx`, way w) is recorded, and 1 otherwise. Bit w corresponds to way number w.
- R4: Pushes fill the lowest-numbered free entry. A recorded entry persists until a clear with `sw_clr_vld` = 1 and `sw_clr_entry` = its number. After that clear it is free from the next edge, and clearing a free entry has no effect.
- R5: `bank_full` is 1 when all DEPTH entries are in use. A push that arrives while the bank is full is not recorded: its location keeps reading valid and the count does not change.
- R6: `err_count` is the number of recorded entries. `bank_empty` is 1 exactly when the count is 0, and `bank_any` is 1 exactly when the count is at least 1. After reset the count is 0.
- R7: A forwarded push alone in its cycle is recorded at the next edge, with the same effect on lookup and allocation as a local push.
- R8: When both ports push in the same cycle, the local location is recorded at the first edge and the forwarded one at the second. At most one entry is added per cycle.
- R9: A push whose location is already recorded is ignored and the count does not change.
- R10: A clear and a push in the same cycle that target the same entry (the push repeats that entry's location, or is written into it) leave the entry recorded.
- R11: A forwarded push is dropped if it arrives while a held forwarded location is still waiting and the local port also pushes. The held location is recorded at the next free cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loc_push_vld | input | 1 | Local recovery push strobe |
| loc_push_idx | input | IDX_W | Local push set index |
| loc_push_way | input | WAY_W | Local push way |
| fwd_push_vld | input | 1 | Forwarded (coherency unit) push strobe |
| fwd_push_idx | input | IDX_W | Forwarded push set index |
| fwd_push_way | input | WAY_W | Forwarded push way |
| lk_valid_in | input | 1 | Valid bit read from the tag array |
| lk_idx | input | IDX_W | Lookup set index |
| lk_way | input | WAY_W | Lookup way |
| lk_valid_out | output | 1 | Valid bit after masking |
| alloc_idx | input | IDX_W | Set index being considered for allocation |
| alloc_ok | output | WAYS | Per-way allocation permission |
| sw_clr_vld | input | 1 | Software clear strobe |
| sw_clr_entry | input | ENT_W | Entry number to clear |
| err_count | output | CNT_W | Number of recorded locations |
| bank_empty | output | 1 | No location recorded |
| bank_any | output | 1 | At least one location recorded |
| bank_full | output | 1 | All entries in use |

## Verification
Lookup masking and allocation masks are combinational from the stored entries. The status outputs are decoded from the same registers. So a push, or a clear, that is present before an edge shows up on every output immediately after that edge. The one exception is a forwarded push that collided with a local push, which shows up one edge later. The bench drives stimulus one time unit after a rising edge, lets exactly one edge pass, and then reads outputs in the quiet part of the cycle. For the collision cases it checks the outputs after the first edge, confirming that only the local location is recorded, and again after the second edge, when the held location must appear. Idle cycles are inserted before some lookups so that persistence is checked against clock edges rather than assumed.

// File: rtl/bad_loc_pkg.sv
package bad_loc_pkg;

    localparam int DEF_IDX_W = 6;
    localparam int DEF_WAYS  = 4;
    localparam int DEF_DEPTH = 4;

    // which source feeds the single store write port this cycle
    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_LOCAL = 2'd1,
        SRC_HELD  = 2'd2,
        SRC_FWD   = 2'd3
    } push_src_e;

    function automatic int clog2_min1(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/bl_push_arb.sv
module bl_push_arb
    import bad_loc_pkg::*;
#(
    parameter int LOC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             loc_vld,
    input  logic [LOC_W-1:0] loc_loc,
    input  logic             fwd_vld,
    input  logic [LOC_W-1:0] fwd_loc,
    output logic             cand_vld,
    output logic [LOC_W-1:0] cand_loc
);

    logic             hold_vld;
    logic [LOC_W-1:0] hold_loc;
    push_src_e        sel;

    // priority: local, then held forwarded, then fresh forwarded
    always_comb begin
        if (loc_vld)       sel = SRC_LOCAL;
        else if (hold_vld) sel = SRC_HELD;
        else if (fwd_vld)  sel = SRC_FWD;
        else               sel = SRC_NONE;
    end

    always_comb begin
        unique case (sel)
            SRC_LOCAL: cand_loc = loc_loc;
            SRC_HELD:  cand_loc = hold_loc;
            SRC_FWD:   cand_loc = fwd_loc;
            default:   cand_loc = '0;
        endcase
        cand_vld = (sel != SRC_NONE);
    end

    // holding register: captures a forwarded push that lost arbitration
    logic hold_load;
    assign hold_load = fwd_vld && (loc_vld ? !hold_vld : hold_vld);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_vld <= 1'b0;
            hold_loc <= '0;
        end else begin
            hold_vld <= loc_vld ? (hold_vld | fwd_vld) : (hold_vld & fwd_vld);
            if (hold_load) hold_loc <= fwd_loc;
        end
    end

endmodule

// File: rtl/bl_store.sv
module bl_store
    import bad_loc_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int WAYS  = 4,
    parameter int DEPTH = 4,
    localparam int WAY_W = clog2_min1(WAYS),
    localparam int ENT_W = clog2_min1(DEPTH),
    localparam int LOC_W = IDX_W + WAY_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cand_vld,
    input  logic [LOC_W-1:0] cand_loc,
    input  logic             clr_vld,
    input  logic [ENT_W-1:0] clr_ent,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [WAY_W-1:0] lk_way,
    input  logic [IDX_W-1:0] alloc_idx,
    output logic [DEPTH-1:0] ent_vld,
    output logic             lk_hit,
    output logic [WAYS-1:0]  alloc_blk
);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [WAY_W-1:0] way;
    } loc_t;

    loc_t             ent_loc [DEPTH];
    loc_t             cand;
    loc_t             lk_key;
    logic [DEPTH-1:0] dup_vec;
    logic [DEPTH-1:0] lk_vec;
    logic             have_free;
    logic [ENT_W-1:0] wr_ptr;
    logic             wr_en;
    logic             clr_eff;

    assign cand   = loc_t'(cand_loc);
    assign lk_key = '{idx: lk_idx, way: lk_way};

    // lowest-numbered free slot
    always_comb begin
        have_free = 1'b0;
        wr_ptr    = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!ent_vld[i]) begin
                have_free = 1'b1;
                wr_ptr    = ENT_W'(i);
            end
        end
    end

    assign wr_en   = cand_vld && !(|dup_vec) && have_free;
    // a push that repeats the cleared entry keeps it alive
    assign clr_eff = clr_vld && !(cand_vld && dup_vec[clr_ent]);
    assign lk_hit  = |lk_vec;

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        assign dup_vec[e] = ent_vld[e] && (ent_loc[e] == cand);
        assign lk_vec[e]  = ent_vld[e] && (ent_loc[e] == lk_key);

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_vld[e] <= 1'b0;
                ent_loc[e] <= '0;
            end else if (wr_en && wr_ptr == ENT_W'(e)) begin
                ent_vld[e] <= 1'b1;
                ent_loc[e] <= cand;
            end else if (clr_eff && clr_ent == ENT_W'(e)) begin
                ent_vld[e] <= 1'b0;
            end
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [DEPTH-1:0] way_hit;
        for (genvar e = 0; e < DEPTH; e++) begin : g_cmp
            assign way_hit[e] = ent_vld[e] && ent_loc[e].idx == alloc_idx
                                && ent_loc[e].way == WAY_W'(w);
        end
        assign alloc_blk[w] = |way_hit;
    end

endmodule

// File: rtl/bl_status.sv
module bl_status #(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH-1:0] ent_vld,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             any_err,
    output logic             full
);

    always_comb begin
        count = '0;
        for (int i = 0; i < DEPTH; i++) count = count + CNT_W'(ent_vld[i]);
    end

    assign empty   = ~|ent_vld;
    assign any_err = |ent_vld;
    assign full    = &ent_vld;

endmodule

// File: rtl/bad_loc_bank.sv
module bad_loc_bank
    import bad_loc_pkg::*;
#(
    parameter int IDX_W = DEF_IDX_W,
    parameter int WAYS  = DEF_WAYS,
    parameter int DEPTH = DEF_DEPTH,
    localparam int WAY_W = clog2_min1(WAYS),
    localparam int ENT_W = clog2_min1(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int LOC_W = IDX_W + WAY_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             loc_push_vld,
    input  logic [IDX_W-1:0] loc_push_idx,
    input  logic [WAY_W-1:0] loc_push_way,
    input  logic             fwd_push_vld,
    input  logic [IDX_W-1:0] fwd_push_idx,
    input  logic [WAY_W-1:0] fwd_push_way,
    input  logic             lk_valid_in,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [WAY_W-1:0] lk_way,
    output logic             lk_valid_out,
    input  logic [IDX_W-1:0] alloc_idx,
    output logic [WAYS-1:0]  alloc_ok,
    input  logic             sw_clr_vld,
    input  logic [ENT_W-1:0] sw_clr_entry,
    output logic [CNT_W-1:0] err_count,
    output logic             bank_empty,
    output logic             bank_any,
    output logic             bank_full
);

    logic             cand_vld;
    logic [LOC_W-1:0] cand_loc;
    logic [DEPTH-1:0] ent_vld;
    logic             lk_hit;
    logic [WAYS-1:0]  alloc_blk;

    bl_push_arb #(.LOC_W(LOC_W)) u_arb (
        .clk      (clk),
        .rst      (rst),
        .loc_vld  (loc_push_vld),
        .loc_loc  ({loc_push_idx, loc_push_way}),
        .fwd_vld  (fwd_push_vld),
        .fwd_loc  ({fwd_push_idx, fwd_push_way}),
        .cand_vld (cand_vld),
        .cand_loc (cand_loc)
    );

    bl_store #(.IDX_W(IDX_W), .WAYS(WAYS), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .cand_vld  (cand_vld),
        .cand_loc  (cand_loc),
        .clr_vld   (sw_clr_vld),
        .clr_ent   (sw_clr_entry),
        .lk_idx    (lk_idx),
        .lk_way    (lk_way),
        .alloc_idx (alloc_idx),
        .ent_vld   (ent_vld),
        .lk_hit    (lk_hit),
        .alloc_blk (alloc_blk)
    );

    bl_status #(.DEPTH(DEPTH)) u_stat (
        .ent_vld (ent_vld),
        .count   (err_count),
        .empty   (bank_empty),
        .any_err (bank_any),
        .full    (bank_full)
    );

    assign lk_valid_out = lk_valid_in & ~lk_hit;
    assign alloc_ok     = ~alloc_blk;

endmodule

// File: rtl/bad_loc_bank_chk.sv
module bad_loc_bank_chk #(
    parameter int WAYS  = 4,
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             lk_valid_in,
    input logic             lk_valid_out,
    input logic [WAYS-1:0]  alloc_ok,
    input logic             sw_clr_vld,
    input logic [CNT_W-1:0] err_count,
    input logic             bank_empty,
    input logic             bank_full
);

    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        int'(err_count) <= DEPTH);

    a_r4_drop_needs_clear: assert property (@(posedge clk) disable iff (rst)
        (err_count < $past(err_count)) |-> $past(sw_clr_vld));

    a_r8_one_add_per_cycle: assert property (@(posedge clk) disable iff (rst)
        int'(err_count) <= int'($past(err_count)) + 1);

    a_r5_full_sticks: assert property (@(posedge clk) disable iff (rst)
        ($past(bank_full) && !$past(sw_clr_vld)) |-> bank_full);

    a_r2_never_raise: assert property (@(posedge clk) disable iff (rst)
        !lk_valid_in |-> !lk_valid_out);

    a_r3_empty_all_alloc: assert property (@(posedge clk) disable iff (rst)
        bank_empty |-> (&alloc_ok));

    a_r6_full_not_empty: assert property (@(posedge clk) disable iff (rst)
        bank_full |-> !bank_empty);

endmodule

bind bad_loc_bank bad_loc_bank_chk #(.WAYS(WAYS), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/bad_loc_bank_tb.sv
module bad_loc_bank_tb;

    localparam int IDX_W = 6;
    localparam int WAYS  = 4;
    localparam int DEPTH = 4;
    localparam int WAY_W = 2;
    localparam int ENT_W = 2;
    localparam int CNT_W = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             loc_push_vld = 1'b0;
    logic [IDX_W-1:0] loc_push_idx = '0;
    logic [WAY_W-1:0] loc_push_way = '0;
    logic             fwd_push_vld = 1'b0;
    logic [IDX_W-1:0] fwd_push_idx = '0;
    logic [WAY_W-1:0] fwd_push_way = '0;
    logic             lk_valid_in = 1'b1;
    logic [IDX_W-1:0] lk_idx = '0;
    logic [WAY_W-1:0] lk_way = '0;
    logic             lk_valid_out;
    logic [IDX_W-1:0] alloc_idx = '0;
    logic [WAYS-1:0]  alloc_ok;
    logic             sw_clr_vld = 1'b0;
    logic [ENT_W-1:0] sw_clr_entry = '0;
    logic [CNT_W-1:0] err_count;
    logic             bank_empty;
    logic             bank_any;
    logic             bank_full;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    bad_loc_bank #(.IDX_W(IDX_W), .WAYS(WAYS), .DEPTH(DEPTH)) u_dut (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic edge1();
        @(posedge clk);
        #1;
        loc_push_vld = 1'b0;
        fwd_push_vld = 1'b0;
        sw_clr_vld   = 1'b0;
    endtask

    // returns masked valid for a lookup with raw valid = 1
    task automatic look(input int idx, input int way, output int v);
        lk_valid_in = 1'b1;
        lk_idx = IDX_W'(idx);
        lk_way = WAY_W'(way);
        #1;
        v = int'(lk_valid_out);
    endtask

    task automatic alloc_q(input int idx, output int m);
        alloc_idx = IDX_W'(idx);
        #1;
        m = int'(alloc_ok);
    endtask

    task automatic t_reset();
        int v;
        int m;
        chk("R6 count after reset", int'(err_count), 0);
        chk("R6 empty after reset", int'(bank_empty), 1);
        chk("R6 any after reset", int'(bank_any), 0);
        chk("R5 full after reset", int'(bank_full), 0);
        look(5, 2, v);
        chk("R2 lookup passes when empty", v, 1);
        alloc_q(5, m);
        chk("R3 alloc all ways when empty", m, 15);
    endtask

    task automatic t_local();
        int v;
        int m;
        loc_push_vld = 1'b1; loc_push_idx = 6'd5; loc_push_way = 2'd2;
        edge1();
        look(5, 2, v);
        chk("R1 pushed location masked", v, 0);
        look(5, 1, v);
        chk("R2 other way passes", v, 1);
        look(6, 2, v);
        chk("R2 other index passes", v, 1);
        lk_valid_in = 1'b0; #1;
        chk("R2 raw invalid stays invalid", int'(lk_valid_out), 0);
        lk_valid_in = 1'b1;
        alloc_q(5, m);
        chk("R3 way 2 blocked at index 5", m, 11);
        alloc_q(6, m);
        chk("R3 index 6 unaffected", m, 15);
        chk("R6 count one", int'(err_count), 1);
        chk("R6 any set", int'(bank_any), 1);
        chk("R6 empty clear", int'(bank_empty), 0);
    endtask

    task automatic t_dup();
        loc_push_vld = 1'b1; loc_push_idx = 6'd5; loc_push_way = 2'd2;
        edge1();
        chk("R9 duplicate ignored", int'(err_count), 1);
    endtask

    task automatic t_fwd();
        int v;
        fwd_push_vld = 1'b1; fwd_push_idx = 6'd9; fwd_push_way = 2'd0;
        edge1();
        look(9, 0, v);
        chk("R7 forwarded location masked", v, 0);
        chk("R7 count two", int'(err_count), 2);
    endtask

    task automatic t_collide();
        int v;
        loc_push_vld = 1'b1; loc_push_idx = 6'd10; loc_push_way = 2'd1;
        fwd_push_vld = 1'b1; fwd_push_idx = 6'd11; fwd_push_way = 2'd3;
        edge1();
        look(10, 1, v);
        chk("R8 local recorded first edge", v, 0);
        look(11, 3, v);
        chk("R8 forwarded not yet recorded", v, 1);
        chk("R8 count after first edge", int'(err_count), 3);
        edge1();
        look(11, 3, v);
        chk("R8 forwarded recorded second edge", v, 0);
        chk("R8 count after second edge", int'(err_count), 4);
        chk("R5 full at depth", int'(bank_full), 1);
    endtask

    task automatic t_full();
        int v;
        loc_push_vld = 1'b1; loc_push_idx = 6'd20; loc_push_way = 2'd0;
        edge1();
        look(20, 0, v);
        chk("R5 push when full not recorded", v, 1);
        chk("R5 count stays at depth", int'(err_count), 4);
    endtask

    task automatic t_clear();
        int v;
        edge1(); edge1(); edge1();
        look(9, 0, v);
        chk("R4 entry persists while idle", v, 0);
        sw_clr_vld = 1'b1; sw_clr_entry = 2'd1;
        edge1();
        look(9, 0, v);
        chk("R4 cleared entry 1 passes", v, 1);
        chk("R4 count after clear", int'(err_count), 3);
        chk("R5 full drops after clear", int'(bank_full), 0);
        look(10, 1, v);
        chk("R4 other entries kept", v, 0);
        sw_clr_vld = 1'b1; sw_clr_entry = 2'd1;
        edge1();
        chk("R4 clearing free entry no effect", int'(err_count), 3);
    endtask

    task automatic t_clr_vs_push();
        int v;
        sw_clr_vld = 1'b1; sw_clr_entry = 2'd0;
        loc_push_vld = 1'b1; loc_push_idx = 6'd5; loc_push_way = 2'd2;
        edge1();
        look(5, 2, v);
        chk("R10 push beats clear", v, 0);
        chk("R10 count unchanged", int'(err_count), 3);
        // free entry 1 is written by a push while cleared
        sw_clr_vld = 1'b1; sw_clr_entry = 2'd1;
        loc_push_vld = 1'b1; loc_push_idx = 6'd20; loc_push_way = 2'd0;
        edge1();
        look(20, 0, v);
        chk("R10 write into cleared slot wins", v, 0);
        chk("R4 lowest free slot used", int'(err_count), 4);
        sw_clr_vld = 1'b1; sw_clr_entry = 2'd1;
        edge1();
        look(20, 0, v);
        chk("R4 new location sits in entry 1", v, 1);
    endtask

    task automatic t_drop();
        int v;
        sw_clr_vld = 1'b1; sw_clr_entry = 2'd2; edge1();
        sw_clr_vld = 1'b1; sw_clr_entry = 2'd3; edge1();
        chk("R6 count after clears", int'(err_count), 1);
        loc_push_vld = 1'b1; loc_push_idx = 6'd30; loc_push_way = 2'd0;
        fwd_push_vld = 1'b1; fwd_push_idx = 6'd31; fwd_push_way = 2'd1;
        @(posedge clk); #1;
        loc_push_vld = 1'b1; loc_push_idx = 6'd32; loc_push_way = 2'd2;
        fwd_push_vld = 1'b1; fwd_push_idx = 6'd33; fwd_push_way = 2'd3;
        edge1();
        look(31, 1, v);
        chk("R11 held location still waiting", v, 1);
        edge1();
        look(31, 1, v);
        chk("R11 held location recorded", v, 0);
        look(33, 3, v);
        chk("R11 second forwarded dropped", v, 1);
        look(32, 2, v);
        chk("R11 second local recorded", v, 0);
        chk("R11 count", int'(err_count), 4);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_local();
        t_dup();
        t_fwd();
        t_collide();
        t_full();
        t_clear();
        t_clr_vs_push();
        t_drop();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule